// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the slave end of a three-wire serial link. The link has an active-high frame enable, a serial clock and one bidirectional data line. A frame opens with a two-bit command. A six-bit register address and data bytes follow the register commands. A stream command instead carries six configuration bits and then an open-ended payload bit stream, which the block hands to a downstream transmitter.

All three pins are brought into the system clock domain through two-flop synchronizers. Clock edges are found by comparing successive synchronized samples. The SCK level seen when EN rises sets the edge roles for the whole frame:

- If SCK is low at enable, bits are captured on falling SCK and read data is launched on rising SCK.
- If SCK is high at enable, the roles are swapped.

Register writes and reads go to an internal 64-entry by 8-bit register file. A stream command issued while `standby` is high starts a start-up timer. Payload bits that arrive before the timer expires are dropped. After a stream frame ends, a guard timer runs. A new frame that opens while the guard timer runs is flagged.

Top module: `spi3_slave`

FSM states and transitions:

| From | Condition | To |
|---|---|---|
| IDLE | EN rises | CMD |
| CMD | 2 bits, 00 or 01 | ADDR |
| CMD | 2 bits, 11 | TXCFG |
| CMD | 2 bits, 10 | SKIP |
| ADDR | 6 bits, command was a read | RDATA |
| ADDR | 6 bits, command was a write | WDATA |
| WDATA | each completed byte | WDATA |
| RDATA | launch edge after the 8th bit | SKIP |
| TXCFG | 6 bits | TXSTRM |
| any state | EN low | IDLE |

## Requirements
- R1: After reset, `sdio_oe`, `tx_cfg_valid`, `tx_bit_valid` and `frame_early` are 0, `tx_ready` is 1, and every register reads 0.
- R2: With SCK low when EN rises, `sdio_in` is captured on falling SCK. The frame is command 00, then address A5..A0, then data D7..D0, all MSB first, and it writes the data to that address.
- R3: With SCK high when EN rises, bits are captured on rising SCK and read data is launched on falling SCK. Frames decode exactly as in R2.
- R4: Command 01 followed by an address returns that register's 8 bits MSB first on `sdio_out`. Bit D7 is launched on the first launch edge after A0 is captured, and each later launch edge gives the next bit.
- R5: In a write frame, every further complete byte goes to the next address. The address wraps from 63 to 0.
- R6: `sdio_oe` is 1 only for the eight bit periods of read data. It is 0 in the period between capturing A0 and launching D7, and it drops at the launch edge that follows D0. `sdio_out` changes only at launch edges.
- R7: EN going low ends the frame at once. A byte that is not yet complete is not written, and `sdio_oe` drops.
- R8: Command 10 is ignored until EN falls. No register is written and no stream output is produced.
- R9: Command 11 takes the next 6 bits MSB first as `tx_cfg`, marked by a one-cycle `tx_cfg_valid` pulse. Each later captured bit appears on `tx_bit` with a one-cycle `tx_bit_valid` pulse, in order, until EN falls.
- R10: Command 11 decoded while `standby` is 1 holds `tx_ready` low for STARTUP_CYC clocks. Payload bits captured while `tx_ready` is low are dropped. Without `standby`, `tx_ready` stays 1.
- R11: When EN falls to end a command-11 frame, a GUARD_CYC-clock window starts. An EN rise inside that window gives a one-cycle `frame_early` pulse. An EN rise after the window gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Frame enable, active high |
| sck | input | 1 | Serial clock |
| sdio_in | input | 1 | Data line as received at the pad |
| standby | input | 1 | Transmitter is in standby |
| sdio_out | output | 1 | Data the slave drives on the pad |
| sdio_oe | output | 1 | Pad output enable |
| tx_cfg | output | CFGW | Configuration bits of a stream frame |
| tx_cfg_valid | output | 1 | One-cycle strobe for `tx_cfg` |
| tx_bit | output | 1 | Payload bit |
| tx_bit_valid | output | 1 | One-cycle strobe for `tx_bit` |
| tx_ready | output | 1 | Start-up delay has expired |
| frame_early | output | 1 | Frame opened inside the guard window |

## Verification
Two functions can fall in the same cycle.

- **Guard and new frame.** The guard timer and the detection of a new frame's EN rise can coincide. The bench opens a frame a few clocks after a stream frame closes and expects exactly one `frame_early` pulse. It then repeats the sequence after more than GUARD_CYC clocks and expects no pulse.
- **Start-up timer and capture.** Expiry of the start-up timer can coincide with a payload capture. The bench streams a known pattern after a standby stream command. It requires that the bits which do arrive are exactly the tail of the sent pattern, and that at least one bit was dropped.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_TXCFG,
        ST_TXSTRM,
        ST_SKIP
    } st_e;

    localparam logic [1:0] CMD_WR = 2'b00;
    localparam logic [1:0] CMD_RD = 2'b01;
    localparam logic [1:0] CMD_TX = 2'b11;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spi3_delay.sv
module spi3_delay #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi3_slave.sv
module spi3_slave
    import spi3_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 8,
    parameter int CFGW        = 6,
    parameter int STARTUP_CYC = 250000,
    parameter int GUARD_CYC   = 25000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            sck,
    input  logic            sdio_in,
    input  logic            standby,
    output logic            sdio_out,
    output logic            sdio_oe,
    output logic [CFGW-1:0] tx_cfg,
    output logic            tx_cfg_valid,
    output logic            tx_bit,
    output logic            tx_bit_valid,
    output logic            tx_ready,
    output logic            frame_early
);
    localparam int CNTW = $clog2(DW + 1);
    localparam logic [CNTW-1:0] CMD_LAST = CNTW'(1);
    localparam logic [CNTW-1:0] ADR_LAST = CNTW'(AW - 1);
    localparam logic [CNTW-1:0] DAT_LAST = CNTW'(DW - 1);
    localparam logic [CNTW-1:0] DAT_FULL = CNTW'(DW);
    localparam logic [CNTW-1:0] CFG_LAST = CNTW'(CFGW - 1);

    // Synchronized pins and edge detection
    logic [2:0] pins_s;
    logic en_s, sck_s, din_s, en_d, sck_d, mode_q, mode_now;
    logic en_rise, en_fall, sck_rise, sck_fall, smp_edge, drv_edge;

    spi3_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({en, sck, sdio_in}),
        .q     (pins_s)
    );

    assign {en_s, sck_s, din_s} = pins_s;
    assign en_rise  = en_s & ~en_d;
    assign en_fall  = ~en_s & en_d;
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign mode_now = en_rise ? sck_s : mode_q;
    assign smp_edge = mode_now ? sck_rise : sck_fall;
    assign drv_edge = mode_now ? sck_fall : sck_rise;

    // Frame state
    st_e                st_q, st_d;
    logic [CNTW-1:0]    cnt_q;
    logic [DW-2:0]      sh_q;
    logic [1:0]         cmd_q;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      rd_q;
    logic               out_q, bitv_q, bit_q, cfgv_q, early_q;
    logic [CFGW-1:0]    cfg_q;

    logic [1:0]         cmd_now;
    logic [AW-1:0]      raddr;
    logic [DW-1:0]      rdata;
    logic               we, startup_go, startup_busy, guard_go, guard_busy;

    assign cmd_now = {sh_q[0], din_s};
    assign raddr   = {sh_q[AW-2:0], din_s};
    assign we      = en_s && (st_q == ST_WDATA) && smp_edge && (cnt_q == DAT_LAST);

    assign startup_go = en_s && (st_q == ST_CMD) && smp_edge && (cnt_q == CMD_LAST)
                        && (cmd_now == CMD_TX) && standby;
    assign guard_go   = en_fall && ((st_q == ST_TXCFG) || (st_q == ST_TXSTRM));

    spi3_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (addr_q),
        .wdata ({sh_q, din_s}),
        .raddr (raddr),
        .rdata (rdata)
    );

    spi3_delay #(.CYC(STARTUP_CYC)) u_startup (
        .clk   (clk),
        .rst_n (rst_n),
        .start (startup_go),
        .busy  (startup_busy)
    );

    spi3_delay #(.CYC(GUARD_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (guard_go),
        .busy  (guard_busy)
    );

    // Next state
    always_comb begin
        st_d = st_q;
        if (!en_s) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (en_rise) st_d = ST_CMD;
                ST_CMD:   if (smp_edge && cnt_q == CMD_LAST) begin
                              if (cmd_now == CMD_WR || cmd_now == CMD_RD) st_d = ST_ADDR;
                              else if (cmd_now == CMD_TX)                  st_d = ST_TXCFG;
                              else                                         st_d = ST_SKIP;
                          end
                ST_ADDR:  if (smp_edge && cnt_q == ADR_LAST)
                              st_d = (cmd_q == CMD_RD) ? ST_RDATA : ST_WDATA;
                ST_WDATA: st_d = ST_WDATA;
                ST_RDATA: if (drv_edge && cnt_q == DAT_FULL) st_d = ST_SKIP;
                ST_TXCFG: if (smp_edge && cnt_q == CFG_LAST) st_d = ST_TXSTRM;
                ST_TXSTRM: st_d = ST_TXSTRM;
                ST_SKIP:  st_d = ST_SKIP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d    <= 1'b0;
            sck_d   <= 1'b0;
            mode_q  <= 1'b0;
            cnt_q   <= '0;
            sh_q    <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            rd_q    <= '0;
            out_q   <= 1'b0;
            bit_q   <= 1'b0;
            bitv_q  <= 1'b0;
            cfg_q   <= '0;
            cfgv_q  <= 1'b0;
            early_q <= 1'b0;
        end else begin
            en_d    <= en_s;
            sck_d   <= sck_s;
            mode_q  <= mode_now;
            bitv_q  <= 1'b0;
            cfgv_q  <= 1'b0;
            early_q <= en_rise && guard_busy;
            if (!en_s || st_q == ST_IDLE) begin
                cnt_q <= '0;
            end else begin
                unique case (st_q)
                    ST_CMD, ST_ADDR, ST_WDATA, ST_TXCFG: if (smp_edge) begin
                        sh_q <= {sh_q[DW-3:0], din_s};
                        if (st_q == ST_CMD && cnt_q == CMD_LAST) begin
                            cmd_q <= cmd_now;
                            cnt_q <= '0;
                        end else if (st_q == ST_ADDR && cnt_q == ADR_LAST) begin
                            addr_q <= raddr;
                            rd_q   <= rdata;
                            cnt_q  <= '0;
                        end else if (st_q == ST_WDATA && cnt_q == DAT_LAST) begin
                            addr_q <= addr_q + 1'b1;
                            cnt_q  <= '0;
                        end else if (st_q == ST_TXCFG && cnt_q == CFG_LAST) begin
                            cfg_q  <= {sh_q[CFGW-2:0], din_s};
                            cfgv_q <= 1'b1;
                            cnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_RDATA: if (drv_edge && cnt_q != DAT_FULL) begin
                        out_q <= rd_q[DW-1];
                        rd_q  <= {rd_q[DW-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ST_TXSTRM: if (smp_edge && !startup_busy) begin
                        bit_q  <= din_s;
                        bitv_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sdio_out     = out_q;
    assign sdio_oe      = (st_q == ST_RDATA) && (cnt_q != '0);
    assign tx_cfg       = cfg_q;
    assign tx_cfg_valid = cfgv_q;
    assign tx_bit       = bit_q;
    assign tx_bit_valid = bitv_q;
    assign tx_ready     = !startup_busy;
    assign frame_early  = early_q;
endmodule

// File: rtl/spi3_slave_chk.sv
module spi3_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic en_rise,
    input logic drv_edge,
    input logic sdio_oe,
    input logic sdio_out,
    input logic tx_cfg_valid,
    input logic tx_bit_valid,
    input logic tx_ready,
    input logic frame_early
);
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_s) |=> !sdio_oe); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && !drv_edge) |=> $stable(sdio_out)); // R6

    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> $past(en_s)); // R6

    AST_CFG_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cfg_valid |=> !tx_cfg_valid); // R9

    AST_BIT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_valid |-> $past(tx_ready)); // R10

    AST_EARLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        frame_early |-> $past(en_rise)); // R11
endmodule

bind spi3_slave spi3_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_s         (en_s),
    .en_rise      (en_rise),
    .drv_edge     (drv_edge),
    .sdio_oe      (sdio_oe),
    .sdio_out     (sdio_out),
    .tx_cfg_valid (tx_cfg_valid),
    .tx_bit_valid (tx_bit_valid),
    .tx_ready     (tx_ready),
    .frame_early  (frame_early)
);

// File: tb/spi3_slave_tb.sv
`timescale 1ns/1ps
module spi3_slave_tb;
    localparam int STARTUP = 200;
    localparam int GUARD   = 100;
    localparam int HALF    = 6;

    // {mode[15], unused[14], addr[13:8], data[7:0]}
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 1'b0, 6'd0,  8'hA5},
        {1'b0, 1'b0, 6'd63, 8'h3C},
        {1'b1, 1'b0, 6'd17, 8'hFF},
        {1'b1, 1'b0, 6'd42, 8'h01},
        {1'b0, 1'b0, 6'd5,  8'h80},
        {1'b1, 1'b0, 6'd33, 8'h5A}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, sck = 1'b0, sdio_in = 1'b0, standby = 1'b0;
    logic sdio_out, sdio_oe, tx_cfg_valid, tx_bit, tx_bit_valid, tx_ready, frame_early;
    logic [5:0] tx_cfg;

    int total = 0, fails = 0;
    bit done = 1'b0;
    logic idle = 1'b0;

    // Stream monitor
    logic        clr = 1'b0;
    logic [63:0] rx_v;
    int          rx_n, cfg_n, early_n;
    logic [5:0]  cfg_seen;

    always #2 clk = ~clk;

    spi3_slave #(.STARTUP_CYC(STARTUP), .GUARD_CYC(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sck(sck), .sdio_in(sdio_in),
        .standby(standby), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .tx_cfg(tx_cfg), .tx_cfg_valid(tx_cfg_valid), .tx_bit(tx_bit),
        .tx_bit_valid(tx_bit_valid), .tx_ready(tx_ready), .frame_early(frame_early)
    );

    always @(posedge clk) begin
        if (clr) begin
            rx_v <= '0; rx_n <= 0; cfg_n <= 0; early_n <= 0; cfg_seen <= '0;
        end else begin
            if (tx_bit_valid) begin rx_v <= {rx_v[62:0], tx_bit}; rx_n <= rx_n + 1; end
            if (tx_cfg_valid) begin cfg_seen <= tx_cfg; cfg_n <= cfg_n + 1; end
            if (frame_early) early_n <= early_n + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic xfer(input logic d, output logic q, output logic oe);
        sdio_in = d;
        sck = ~idle;
        repeat (HALF) @(negedge clk);
        q  = sdio_out;
        oe = sdio_oe;
        sck = idle;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [63:0] v);
        logic q, oe;
        for (int i = n - 1; i >= 0; i--) xfer(v[i], q, oe);
    endtask

    task automatic fstart(input logic lvl);
        idle = lvl;
        sck = lvl;
        repeat (4) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic fend();
        repeat (2) @(negedge clk);
        en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic lvl, input logic [5:0] a, input logic [7:0] d);
        fstart(lvl);
        send(2, 2'b00);
        send(6, a);
        send(8, d);
        fend();
    endtask

    task automatic rd(input logic lvl, input logic [5:0] a, output logic [7:0] d,
                      output logic turn_oe, output logic all_oe);
        logic q, oe;
        fstart(lvl);
        send(2, 2'b01);
        send(6, a);
        turn_oe = sdio_oe;
        all_oe  = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xfer(1'b0, q, oe);
            d[i] = q;
            all_oe &= oe;
        end
        fend();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic t_oe, a_oe, q, oe;
        clr = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        clr = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 oe", sdio_oe, 0);
        chk("R1 ready", tx_ready, 1);
        chk("R1 bitv", tx_bit_valid, 0);
        chk("R1 cfgv", tx_cfg_valid, 0);
        chk("R1 early", frame_early, 0);
        rd(1'b0, 6'd9, d, t_oe, a_oe);
        chk("R1 reg", d, 8'h00);

        // Vector table: write each register, read it back in the same mode
        foreach (VEC[i]) wr(VEC[i][15], VEC[i][13:8], VEC[i][7:0]);
        foreach (VEC[i]) begin
            rd(VEC[i][15], VEC[i][13:8], d, t_oe, a_oe);
            chk(VEC[i][15] ? "R3 data" : "R2 data", d, VEC[i][7:0]);
            chk("R4 read", d, VEC[i][7:0]);
            chk("R6 turnaround", t_oe, 0);
            chk("R6 data oe", a_oe, 1);
            chk("R6 after", sdio_oe, 0);
        end

        // R5 burst with wrap
        fstart(1'b0);
        send(2, 2'b00); send(6, 6'd62);
        send(8, 8'h11); send(8, 8'h22); send(8, 8'h33); send(8, 8'h44);
        fend();
        rd(1'b0, 6'd62, d, t_oe, a_oe); chk("R5 62", d, 8'h11);
        rd(1'b1, 6'd63, d, t_oe, a_oe); chk("R5 63", d, 8'h22);
        rd(1'b0, 6'd0,  d, t_oe, a_oe); chk("R5 wrap0", d, 8'h33);
        rd(1'b0, 6'd1,  d, t_oe, a_oe); chk("R5 wrap1", d, 8'h44);

        // R7 abort: partial byte discarded
        wr(1'b0, 6'd20, 8'h77);
        fstart(1'b0); send(2, 2'b00); send(6, 6'd20); send(5, 5'b0); fend();
        rd(1'b0, 6'd20, d, t_oe, a_oe); chk("R7 partial", d, 8'h77);
        fstart(1'b1); send(2, 2'b00); send(6, 6'd21); send(8, 8'h12); send(3, 3'b111); fend();
        rd(1'b0, 6'd21, d, t_oe, a_oe); chk("R7 full byte", d, 8'h12);
        rd(1'b0, 6'd22, d, t_oe, a_oe); chk("R7 dropped", d, 8'h00);
        fstart(1'b0); send(2, 2'b01); send(6, 6'd62);
        xfer(1'b0, q, oe); xfer(1'b0, q, oe);
        chk("R7 oe mid", oe, 1);
        fend();
        chk("R7 oe released", sdio_oe, 0);

        // R8 command 10 ignored
        clear_mon();
        fstart(1'b0); send(2, 2'b10); send(6, 6'd23); send(8, 8'hEE); fend();
        rd(1'b0, 6'd23, d, t_oe, a_oe); chk("R8 reg", d, 8'h00);
        chk("R8 cfg", cfg_n, 0);
        chk("R8 bits", rx_n, 0);

        // R9 stream without standby
        standby = 1'b0;
        clear_mon();
        fstart(1'b0); send(2, 2'b11); send(6, 6'b101101); send(12, 12'hB39); fend();
        chk("R9 cfg count", cfg_n, 1);
        chk("R9 cfg", cfg_seen, 6'b101101);
        chk("R9 bit count", rx_n, 12);
        chk("R9 bits", rx_v[11:0], 12'hB39);
        chk("R10 ready", tx_ready, 1);
        chk("R11 first", early_n, 0);

        // R11 frame inside guard window
        fstart(1'b0); send(2, 2'b10); fend();
        chk("R11 early", early_n, 1);

        // R11 frame after the window
        fstart(1'b1); send(2, 2'b11); send(6, 6'd0); send(4, 4'hF); fend();
        repeat (GUARD + 20) @(negedge clk);
        clear_mon();
        fstart(1'b0); send(2, 2'b10); fend();
        chk("R11 late", early_n, 0);

        // R10 stream from standby
        standby = 1'b1;
        repeat (GUARD + 20) @(negedge clk);
        clear_mon();
        fstart(1'b0);
        send(2, 2'b11);
        chk("R10 not ready", tx_ready, 0);
        send(6, 6'b000111);
        send(24, 24'hC3A5F1);
        fend();
        chk("R10 cfg", cfg_seen, 6'b000111);
        chk("R10 some dropped", (rx_n > 0 && rx_n < 24), 1);
        chk("R10 tail", (rx_v ^ 64'hC3A5F1) & ((64'd1 << rx_n) - 1), 0);
        chk("R10 ready again", tx_ready, 1);
        standby = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule